// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a blocking data cache placed between a processor request port and a memory port that moves whole lines. Each line holds four 32-bit words (16 bytes) and sits at exactly one position, chosen by the line address modulo the number of lines. With the default of 1024 lines the cache holds 16 KB and splits a 32-bit byte address into an 18-bit tag, a 10-bit index and a 4-bit byte offset. Each line keeps a tag, a valid flag, a dirty flag and its 128 data bits.

The processor holds its request valid until the cache pulses ready for one cycle. A hit completes one cycle after the request is accepted. A write hit changes only the cached copy and marks the line dirty. On a miss the controller first sends a dirty victim line to memory, then reads the missing line, and then repeats the lookup, which now hits. Write misses allocate: the line is fetched first, and the write then goes into the cached copy. Memory transfers use their own valid/ready handshake. The controller holds every request field steady until memory answers with a one-cycle ready pulse, however long that takes.

Top module: `dm_wb_cache`

## Requirements
- R1: While reset is held, and in the first cycle after it, cpu_ready and mem_valid are low. After reset every line is invalid, so the first access to any line issues a memory read.
- R2: A read hit raises cpu_ready exactly one clock after the request is accepted, for one cycle only, and returns the addressed word on cpu_rdata. It causes no memory transfer.
- R3: Address bits [3:2] select the word inside a line, the next log2(N_LINES) bits form the index, and the remaining upper bits form the tag. With the default geometry the index is [13:4] and the tag is [31:14]. Two addresses with the same index and different tags compete for the same line.
- R4: A miss issues exactly one memory read (mem_wr = 0) with the line-aligned address, whose low four bits are zero. The processor then receives the requested word taken from the data returned by memory.
- R5: A write miss allocates the line. The line is read from memory, only the addressed word is replaced, and the other three words keep the values memory supplied.
- R6: A write hit causes no memory transfer and finishes in the same number of cycles as a read hit. Memory receives the new data only when the line is later evicted.
- R7: On a miss to a line that is valid and dirty, the controller first writes the old line to memory, at the address built from the old tag and the index, with all its current data. The read of the new line starts in the cycle after that write is acknowledged.
- R8: While mem_valid is high and mem_ready is low, mem_addr, mem_wr and mem_wdata stay unchanged. Any memory latency is accepted.
- R9: cpu_ready is never high in a cycle where mem_valid is high.
- R10: A clean line, meaning it was refilled and never written, is replaced without any memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present; held until cpu_ready |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address (word aligned) |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid while cpu_ready is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory transfer request |
| mem_wr | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | 32 | Line-aligned byte address |
| mem_wdata | output | 128 | Line being written back |
| mem_rdata | input | 128 | Line returned by memory |
| mem_ready | input | 1 | One-cycle acknowledge from memory |

## Verification
The hardest case to reach from the ports is a dirty eviction whose write-back must carry words changed by several earlier write hits. That needs a precise order of events: a refill, then writes that stay inside the cache, then an access with a different tag at the same index. The bench runs a small eight-line configuration. It fills every line, rewrites every word, and then sweeps conflicting tags across all indices. A seeded mixed sequence over three tags follows, with memory latencies that change from one transfer to the next. A reference model of tags and dirty flags predicts for every access whether a hit, a clean refill or a write-back followed by a refill is due, and a golden word image predicts both the returned data and the contents of each evicted line.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 4;
    localparam int LINE_W     = WORD_W * LINE_WORDS;
    localparam int BYTE_W     = $clog2(WORD_W / 8);
    localparam int WSEL_W     = $clog2(LINE_WORDS);
    localparam int OFF_W      = BYTE_W + WSEL_W;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_COMPARE   = 2'd1,
        ST_WRITEBACK = 2'd2,
        ST_REFILL    = 2'd3
    } dmc_state_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } dmc_req_t;

    function automatic logic [LINE_WORDS-1:0] word_onehot(input logic [WSEL_W-1:0] sel);
        logic [LINE_WORDS-1:0] m;
        m = '0;
        m[sel] = 1'b1;
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] line,
                                                    input logic [WSEL_W-1:0] sel);
        return line[sel*WORD_W +: WORD_W];
    endfunction

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store
    import dmc_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int TAG_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic             fill_we,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             mark_dirty,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0] tags [LINES];
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;

    // Flags carry reset; tags do not need it because valid gates them.
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_we) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (mark_dirty) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_we) begin
            tags[idx] <= fill_tag;
        end
    end

    assign rd_tag   = tags[idx];
    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store
    import dmc_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic                  clk,
    input  logic [IDX_W-1:0]      idx,
    input  logic                  we,
    input  logic [LINE_WORDS-1:0] wmask,
    input  logic [LINE_W-1:0]     wline,
    output logic [LINE_W-1:0]     rline
);
    localparam int LINES = 1 << IDX_W;

    logic [LINE_W-1:0] lines [LINES];
    logic [LINE_W-1:0] merged;

    // Per-word merge so a single write port serves both refill and word store.
    for (genvar g = 0; g < LINE_WORDS; g++) begin : g_merge
        assign merged[g*WORD_W +: WORD_W] = wmask[g] ? wline[g*WORD_W +: WORD_W]
                                                     : rline[g*WORD_W +: WORD_W];
    end

    always_ff @(posedge clk) begin
        if (we) begin
            lines[idx] <= merged;
        end
    end

    assign rline = lines[idx];

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int TAG_W = 18
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cpu_valid,
    input  logic                  cpu_wr,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [WORD_W-1:0]     cpu_wdata,
    output logic [WORD_W-1:0]     cpu_rdata,
    output logic                  cpu_ready,
    output logic                  mem_valid,
    output logic                  mem_wr,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [LINE_W-1:0]     mem_wdata,
    input  logic [LINE_W-1:0]     mem_rdata,
    input  logic                  mem_ready,
    output logic [IDX_W-1:0]      idx,
    input  logic [TAG_W-1:0]      st_tag,
    input  logic                  st_valid,
    input  logic                  st_dirty,
    output logic                  fill_we,
    output logic [TAG_W-1:0]      fill_tag,
    output logic                  mark_dirty,
    input  logic [LINE_W-1:0]     rline,
    output logic                  data_we,
    output logic [LINE_WORDS-1:0] data_wmask,
    output logic [LINE_W-1:0]     data_wline
);
    dmc_state_e state_q, state_d;
    dmc_req_t   req_q;

    logic [TAG_W-1:0]  req_tag;
    logic [WSEL_W-1:0] req_wsel;
    logic              hit;

    assign req_tag  = req_q.addr[ADDR_W-1 -: TAG_W];
    assign idx      = req_q.addr[OFF_W +: IDX_W];
    assign req_wsel = req_q.addr[BYTE_W +: WSEL_W];
    assign hit      = st_valid && (st_tag == req_tag);
    assign fill_tag = req_tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cpu_valid) begin
                req_q.wr    <= cpu_wr;
                req_q.addr  <= cpu_addr;
                req_q.wdata <= cpu_wdata;
            end
        end
    end

    always_comb begin
        state_d    = state_q;
        cpu_ready  = 1'b0;
        mem_valid  = 1'b0;
        mem_wr     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        fill_we    = 1'b0;
        mark_dirty = 1'b0;
        data_we    = 1'b0;
        data_wmask = '0;
        data_wline = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_valid) begin
                    state_d = ST_COMPARE;
                end
            end
            ST_COMPARE: begin
                if (hit) begin
                    cpu_ready = 1'b1;
                    state_d   = ST_IDLE;
                    if (req_q.wr) begin
                        data_we    = 1'b1;
                        data_wmask = word_onehot(req_wsel);
                        data_wline = {LINE_WORDS{req_q.wdata}};
                        mark_dirty = 1'b1;
                    end
                end else if (st_valid && st_dirty) begin
                    state_d = ST_WRITEBACK;
                end else begin
                    state_d = ST_REFILL;
                end
            end
            ST_WRITEBACK: begin
                mem_valid = 1'b1;
                mem_wr    = 1'b1;
                mem_addr  = {st_tag, idx, {OFF_W{1'b0}}};
                mem_wdata = rline;
                if (mem_ready) begin
                    state_d = ST_REFILL;
                end
            end
            ST_REFILL: begin
                mem_valid = 1'b1;
                mem_addr  = {req_tag, idx, {OFF_W{1'b0}}};
                if (mem_ready) begin
                    fill_we    = 1'b1;
                    data_we    = 1'b1;
                    data_wmask = '1;
                    data_wline = mem_rdata;
                    state_d    = ST_COMPARE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign cpu_rdata = pick_word(rline, req_wsel);

endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
    import dmc_pkg::*;
#(
    parameter int N_LINES = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_wr,
    input  logic [31:0]       cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_valid,
    output logic              mem_wr,
    output logic [31:0]       mem_addr,
    output logic [127:0]      mem_wdata,
    input  logic [127:0]      mem_rdata,
    input  logic              mem_ready
);
    localparam int IDX_W = $clog2(N_LINES);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [IDX_W-1:0]      idx;
    logic [TAG_W-1:0]      st_tag;
    logic                  st_valid;
    logic                  st_dirty;
    logic                  fill_we;
    logic [TAG_W-1:0]      fill_tag;
    logic                  mark_dirty;
    logic [LINE_W-1:0]     rline;
    logic                  data_we;
    logic [LINE_WORDS-1:0] data_wmask;
    logic [LINE_W-1:0]     data_wline;

    dmc_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cpu_valid  (cpu_valid),
        .cpu_wr     (cpu_wr),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .cpu_ready  (cpu_ready),
        .mem_valid  (mem_valid),
        .mem_wr     (mem_wr),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ready  (mem_ready),
        .idx        (idx),
        .st_tag     (st_tag),
        .st_valid   (st_valid),
        .st_dirty   (st_dirty),
        .fill_we    (fill_we),
        .fill_tag   (fill_tag),
        .mark_dirty (mark_dirty),
        .rline      (rline),
        .data_we    (data_we),
        .data_wmask (data_wmask),
        .data_wline (data_wline)
    );

    dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk        (clk),
        .rst        (rst),
        .idx        (idx),
        .fill_we    (fill_we),
        .fill_tag   (fill_tag),
        .mark_dirty (mark_dirty),
        .rd_tag     (st_tag),
        .rd_valid   (st_valid),
        .rd_dirty   (st_dirty)
    );

    dmc_data_store #(.IDX_W(IDX_W)) u_data (
        .clk   (clk),
        .idx   (idx),
        .we    (data_we),
        .wmask (data_wmask),
        .wline (data_wline),
        .rline (rline)
    );

endmodule

// File: rtl/dmc_chk.sv
module dmc_chk (
    input logic         clk,
    input logic         rst,
    input logic         cpu_ready,
    input logic         mem_valid,
    input logic         mem_wr,
    input logic         mem_ready,
    input logic [31:0]  mem_addr,
    input logic [127:0] mem_wdata
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!cpu_ready && !mem_valid));

    // R2
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    // R4
    line_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr[3:0] == 4'd0));

    // R7
    wb_then_refill_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_wr && mem_ready) |=> (mem_valid && !mem_wr));

    // R8
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_wr) && $stable(mem_wdata)));

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(cpu_ready && mem_valid));

endmodule

bind dm_wb_cache dmc_chk u_dmc_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_ready (cpu_ready),
    .mem_valid (mem_valid),
    .mem_wr    (mem_wr),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/sim_dm_wb_cache.sv
`timescale 1ns/1ps
module sim_dm_wb_cache;
    localparam int LINES = 8;
    localparam int SH    = 7;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cpu_valid = 1'b0, cpu_wr = 1'b0;
    logic [31:0]  cpu_addr = '0, cpu_wdata = '0, cpu_rdata;
    logic         cpu_ready, mem_valid, mem_wr, mem_ready = 1'b0;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata, mem_rdata = '0;

    always #4 clk = ~clk;

    dm_wb_cache #(.N_LINES(LINES)) u0 (.*);

    int checks = 0, errors = 0;
    bit done = 0;
    int rd_n = 0, wr_n = 0, op_no = 0, last_rd_no = 0, last_wr_no = 0;
    logic [31:0] last_rd_ba, last_wr_ba;
    bit [31:0]  gold  [bit [31:0]];
    bit [127:0] mem_m [bit [31:0]];
    bit         m_v [LINES];
    bit         m_d [LINES];
    bit [24:0]  m_t [LINES];

    task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic bit [31:0] init_w(input bit [31:0] a);
        return ((a >> 2) * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    function automatic bit [31:0] gword(input bit [31:0] a);
        return gold.exists(a >> 2) ? gold[a >> 2] : init_w(a);
    endfunction

    function automatic bit [127:0] gblk(input bit [31:0] ba);
        return {gword(ba + 12), gword(ba + 8), gword(ba + 4), gword(ba)};
    endfunction

    function automatic bit [127:0] mblk(input bit [31:0] ba);
        return mem_m.exists(ba) ? mem_m[ba]
                                : {init_w(ba + 12), init_w(ba + 8), init_w(ba + 4), init_w(ba)};
    endfunction

    // Memory responder with a latency that rotates 0..3 cycles (R8)
    initial begin
        int lat = 0;
        forever begin
            @(negedge clk);
            if (mem_valid && !rst) begin
                logic [31:0] a0;
                a0 = mem_addr;
                repeat (lat) @(negedge clk);
                lat = (lat + 1) % 4;
                chk(mem_valid && mem_addr == a0, "R8", {96'd0, mem_addr}, {96'd0, a0});
                op_no++;
                if (mem_wr) begin
                    mem_m[mem_addr] = mem_wdata;
                    wr_n++; last_wr_ba = mem_addr; last_wr_no = op_no;
                end else begin
                    mem_rdata = mblk(mem_addr);
                    rd_n++; last_rd_ba = mem_addr; last_rd_no = op_no;
                end
                mem_ready = 1'b1;
                @(negedge clk);
                mem_ready = 1'b0;
            end
        end
    end

    function automatic bit [31:0] mk(input int tag, input int idx, input int w);
        return (32'(tag) << SH) | (32'(idx) << 4) | (32'(w) << 2);
    endfunction

    task automatic acc(input bit wr, input bit [31:0] a, input bit [31:0] wd, input string lbl);
        int idx, cyc, rd0, wr0;
        bit [24:0] tag;
        bit exp_hit, exp_wb;
        bit [31:0] old_ba, got;
        idx = int'(a[6:4]);
        tag = a[31:SH];
        exp_hit = m_v[idx] && m_t[idx] == tag;
        exp_wb  = !exp_hit && m_v[idx] && m_d[idx];
        old_ba  = (32'(m_t[idx]) << SH) | (32'(idx) << 4);
        rd0 = rd_n; wr0 = wr_n;
        @(negedge clk);
        cpu_valid = 1'b1; cpu_wr = wr; cpu_addr = a; cpu_wdata = wd;
        cyc = 0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            if (cpu_ready && mem_valid) chk(0, "R9", 1, 0);
            if (cpu_ready) break;
            if (cyc > 2000) begin chk(0, "watchdog-access", 0, 1); break; end
        end
        got = cpu_rdata;
        cpu_valid = 1'b0;
        @(posedge clk);
        if (!wr) chk(got == gword(a), exp_hit ? "R2" : "R4", {96'd0, got}, {96'd0, gword(a)});
        else gold[a >> 2] = wd;
        if (exp_hit) begin
            chk(cyc == 1, wr ? "R6" : "R2", 128'(cyc), 1);
            chk(rd_n == rd0 && wr_n == wr0, wr ? "R6" : "R2", 128'(rd_n + wr_n), 128'(rd0 + wr0));
        end else begin
            chk(rd_n == rd0 + 1, lbl, 128'(rd_n - rd0), 1);
            chk(last_rd_ba == (a & ~32'hF), "R4", {96'd0, last_rd_ba}, {96'd0, a & ~32'hF});
            chk(wr_n == wr0 + int'(exp_wb), exp_wb ? "R7" : "R10", 128'(wr_n - wr0), 128'(exp_wb));
            if (exp_wb) begin
                chk(last_wr_ba == old_ba, "R7", {96'd0, last_wr_ba}, {96'd0, old_ba});
                chk(last_wr_no < last_rd_no, "R7", 128'(last_wr_no), 128'(last_rd_no));
                chk(mblk(old_ba) == gblk(old_ba), "R7", mblk(old_ba), gblk(old_ba));
            end
            m_v[idx] = 1; m_t[idx] = tag; m_d[idx] = 0;
        end
        if (wr) m_d[idx] = 1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 chk(!cpu_ready && !mem_valid, "R1", {cpu_ready, mem_valid}, 0);
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #1;
        chk(!cpu_ready && !mem_valid, "R1", {cpu_ready, mem_valid}, 0);
        // Cold sweep: every line misses once after reset
        for (int i = 0; i < LINES; i++)
            for (int w = 0; w < 4; w++) acc(0, mk(1, i, w), 0, "R1");
        // Rewrite every word: write hits stay in cache
        for (int i = 0; i < LINES; i++)
            for (int w = 0; w < 4; w++) acc(1, mk(1, i, w), 32'hC0DE_0000 + 32'(i * 4 + w), "R6");
        // Conflicting tag on each index: dirty victims written back
        for (int i = 0; i < LINES; i++) acc(0, mk(2, i, i % 4), 0, "R3");
        // Write misses on clean lines: allocate then merge
        for (int i = 0; i < LINES; i++) begin
            acc(1, mk(3, i, 1), 32'hBEEF_0000 + 32'(i), "R5");
            acc(0, mk(3, i, 0), 0, "R5");
            acc(0, mk(3, i, 1), 0, "R5");
            acc(0, mk(3, i, 3), 0, "R5");
        end
        // Seeded mixed traffic over three tags
        begin
            bit [31:0] s = 32'h1234_5678;
            for (int n = 0; n < 600; n++) begin
                s = s * 1103515245 + 12345;
                acc(s[20], mk(int'((s >> 16) % 3) + 1, int'((s >> 8) & 7), int'((s >> 4) & 3)),
                    s ^ 32'h0F0F_F0F0, "R4");
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule